// File: doc/BRIEF.md
# Byte-to-Serial Stream Adapter

This block drains bytes from an upstream byte FIFO and sends them as a one-bit stream onto a serial link. A controller state machine drives a byte-wide shift register. It loads a byte from the FIFO head, then shifts it out one bit per slot that the link accepts, least significant bit first. The FIFO head is popped during the first bit slot, so the next byte is already showing by the time the last bit goes out. That next byte is loaded in the final slot, so consecutive bytes leave with no idle slot between them.

The FIFO is a show-ahead FIFO: `fifo_data` shows the head entry whenever `fifo_empty` is low, and a `fifo_pop` seen at a rising edge removes that entry. The link takes a bit at every rising edge where `ser_valid` and `link_ready` are both high. When `link_ready` is low the stream stands still. When the FIFO runs dry at a byte boundary, the controller drops back to idle until data arrives.

States: `ST_IDLE` (no data, valid low), `ST_FIRST` (bit 0 slot), `ST_MID` (bit 1 to bit 6 slots, with a slot index), `ST_LAST` (bit 7 slot). Transitions:
- `ST_IDLE`→`ST_FIRST` when the FIFO is non-empty (load).
- `ST_FIRST`→`ST_MID` on ready (shift, pop).
- `ST_MID`→`ST_MID` on ready until index 6.
- `ST_MID`→`ST_LAST` on ready at index 6.
- `ST_LAST`→`ST_FIRST` on ready with data present (reload).
- `ST_LAST`→`ST_IDLE` on ready with the FIFO empty (shift out to zero).
- Every state holds while ready is low, except `ST_IDLE`, which does not depend on ready.

Top module: `byte_serializer`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) leaves `ser_valid` = 0, `fifo_pop` = 0 and `ser_data` = 0 once released, with the FIFO empty.
- R2: Each byte is sent as exactly 8 accepted bit slots, bit 0 first and bit 7 last, and `ser_data` in an accepted slot equals that bit of the byte.
- R3: When idle (`ser_valid` = 0) and the FIFO is non-empty at a rising edge, the byte is loaded and `ser_valid` is 1 with bit 0 in the next cycle.
- R4: `fifo_pop` is high only in a cycle where bit 0 of a byte is accepted (`ser_valid` = 1 and `link_ready` = 1), once per byte.
- R5: When bit 7 is accepted and the FIFO is non-empty at that edge, `ser_valid` stays 1 in the next cycle and carries bit 0 of the next byte.
- R6: While `ser_valid` = 1 and `link_ready` = 0, the next cycle keeps `ser_valid` = 1 and `ser_data` unchanged.
- R7: When bit 7 is accepted and the FIFO is empty at that edge, `ser_valid` is 0 in the next cycle and stays 0 while the FIFO stays empty.
- R8: `fifo_pop` is never high while `fifo_empty` is high.
- R9: `ser_valid` is high only in slots that carry data of a byte taken from the FIFO: inside a byte it stays high, and the number of accepted bits equals 8 times the number of bytes taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fifo_data | input | DATA_W | Head entry of the upstream FIFO |
| fifo_empty | input | 1 | FIFO holds no entry |
| fifo_pop | output | 1 | Remove the FIFO head at this edge |
| link_ready | input | 1 | Link accepts a bit at this edge |
| ser_data | output | 1 | Serial bit, shift register LSB |
| ser_valid | output | 1 | `ser_data` carries a real bit |

## Verification
`ser_valid` and `ser_data` are registered and change one edge after the edge that loads, shifts or holds. `fifo_pop` is combinational and depends on the current state and on `link_ready` in the same cycle. The bench sets all inputs just after each falling edge and samples one time unit later. Pops are compared in the sampling cycle itself. A stall, a reload or an idle entry is checked against a decision saved from the previous sample, since it shows one edge later. The FIFO model drops its head at the falling edge that follows an observed pop, because the design reads `fifo_data` again only in the final slot of a byte.

// File: rtl/ser_pkg.sv
package ser_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_MID   = 2'd2,
        ST_LAST  = 2'd3
    } ser_state_t;
endpackage

// File: rtl/ser_shreg.sv
module ser_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         lsb
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (load)  q <= din;
        else if (shift) q <= {1'b0, q[W-1:1]};
    end

    assign lsb = q[0];
endmodule

// File: rtl/ser_ctrl.sv
module ser_ctrl
    import ser_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic fifo_empty,
    input  logic link_ready,
    output logic load,
    output logic shift,
    output logic pop,
    output logic valid
);
    localparam int IDX_W    = $clog2(BITS);
    localparam int LAST_MID = BITS - 2;

    ser_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!fifo_empty) state_d = ST_FIRST;
            end
            ST_FIRST: begin
                if (link_ready) begin
                    state_d = ST_MID;
                    idx_d   = IDX_W'(1);
                end
            end
            ST_MID: begin
                if (link_ready) begin
                    idx_d = idx_q + IDX_W'(1);
                    if (idx_q == IDX_W'(LAST_MID)) state_d = ST_LAST;
                end
            end
            ST_LAST: begin
                if (link_ready) state_d = fifo_empty ? ST_IDLE : ST_FIRST;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // outputs
    always_comb begin
        load  = 1'b0;
        shift = 1'b0;
        pop   = 1'b0;
        valid = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                valid = 1'b0;
                load  = !fifo_empty;
            end
            ST_FIRST: begin
                shift = link_ready;
                pop   = link_ready && !fifo_empty;
            end
            ST_MID: begin
                shift = link_ready;
            end
            ST_LAST: begin
                load  = link_ready && !fifo_empty;
                shift = link_ready && fifo_empty;
            end
        endcase
    end
endmodule

// File: rtl/byte_serializer.sv
module byte_serializer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic              fifo_empty,
    output logic              fifo_pop,
    input  logic              link_ready,
    output logic              ser_data,
    output logic              ser_valid
);
    logic do_load, do_shift;

    ser_ctrl #(.BITS(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .fifo_empty(fifo_empty),
        .link_ready(link_ready),
        .load      (do_load),
        .shift     (do_shift),
        .pop       (fifo_pop),
        .valid     (ser_valid)
    );

    ser_shreg #(.W(DATA_W)) u_shreg (
        .clk  (clk),
        .rst  (rst),
        .load (do_load),
        .shift(do_shift),
        .din  (fifo_data),
        .lsb  (ser_data)
    );
endmodule

// File: rtl/ser_chk.sv
module ser_chk #(
    parameter int DATA_W = 8
) (
    input logic clk,
    input logic rst,
    input logic fifo_empty,
    input logic fifo_pop,
    input logic link_ready,
    input logic ser_data,
    input logic ser_valid
);
    localparam int CW = $clog2(DATA_W);

    logic          acc;
    logic [CW-1:0] cnt;

    assign acc = ser_valid && link_ready;

    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (acc) cnt <= cnt + CW'(1);
    end

    // R8
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> !fifo_empty);
    // R4
    pop_slot_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> (acc && cnt == '0));
    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ser_valid && !link_ready) |=> (ser_valid && $stable(ser_data)));
    // R3
    idle_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!ser_valid && !fifo_empty) |=> ser_valid);
    // R5
    no_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && cnt == CW'(DATA_W-1) && !fifo_empty) |=> ser_valid);
    // R7
    drain_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && cnt == CW'(DATA_W-1) && fifo_empty) |=> !ser_valid);
    // R9
    mid_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && cnt != CW'(DATA_W-1)) |=> ser_valid);
endmodule

bind byte_serializer ser_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fifo_empty(fifo_empty),
    .fifo_pop  (fifo_pop),
    .link_ready(link_ready),
    .ser_data  (ser_data),
    .ser_valid (ser_valid)
);

// File: tb/byte_serializer_tb.sv
module byte_serializer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] fifo_data = '0;
    logic       fifo_empty = 1'b1;
    logic       fifo_pop;
    logic       link_ready = 1'b0;
    logic       ser_data;
    logic       ser_valid;

    int errors = 0;
    int checks = 0;

    logic [7:0] fq[$];
    logic       exp_bits[$];
    int         bitpos = 0;
    logic       last_pop = 1'b0;
    logic       prev_stall = 1'b0;
    logic       prev_data = 1'b0;
    logic       have_exp = 1'b0;
    logic       exp_valid = 1'b0;
    int         ready_pct = 100;
    int         push_pct = 0;
    int         seed_dummy;

    always #5 clk = ~clk;

    byte_serializer u_dut (
        .clk(clk), .rst(rst), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
        .fifo_pop(fifo_pop), .link_ready(link_ready),
        .ser_data(ser_data), .ser_valid(ser_valid)
    );

    function automatic logic bit_of(input logic [7:0] b, input int i);
        return b[i];
    endfunction

    function automatic logic pop_due(input logic v, input logic r, input int pos);
        return v && r && (pos == 0);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push_byte(input logic [7:0] b);
        fq.push_back(b);
        for (int i = 0; i < 8; i++) exp_bits.push_back(bit_of(b, i));
    endtask

    task automatic step();
        logic acc;
        @(negedge clk);
        if (last_pop && fq.size() > 0) void'(fq.pop_front());
        if (push_pct > 0 && fq.size() < 4 && ($urandom % 100) < push_pct)
            push_byte(8'($urandom));
        link_ready = (($urandom % 100) < ready_pct);
        fifo_empty = (fq.size() == 0);
        fifo_data  = (fq.size() > 0) ? fq[0] : 8'h00;
        #1;
        acc = ser_valid && link_ready;
        // R4: pop only in the accepted bit-0 slot
        check("R4", fifo_pop, pop_due(ser_valid, link_ready, bitpos));
        // R8
        if (fifo_empty) check("R8", fifo_pop, 1'b0);
        // R6
        if (prev_stall) begin
            check("R6 valid", ser_valid, 1'b1);
            check("R6 data", ser_data, prev_data);
        end
        // R3 / R5 / R7 / R9
        if (have_exp) check("R3/R5/R7/R9 valid", ser_valid, exp_valid);
        // R2
        if (acc) begin
            if (exp_bits.size() == 0) check("R9 extra bit", 1'b1, 1'b0);
            else check("R2", ser_data, exp_bits.pop_front());
        end
        prev_stall = ser_valid && !link_ready;
        prev_data  = ser_data;
        have_exp   = 1'b1;
        if (acc && bitpos == 7) exp_valid = !fifo_empty;
        else if (!ser_valid)    exp_valid = !fifo_empty;
        else                    exp_valid = 1'b1;
        if (acc) bitpos = (bitpos + 1) % 8;
        last_pop = fifo_pop;
    endtask

    initial begin
        seed_dummy = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1
        check("R1 valid", ser_valid, 1'b0);
        check("R1 pop", fifo_pop, 1'b0);
        check("R1 data", ser_data, 1'b0);

        // single byte, then drain to idle (R3, R7)
        push_byte(8'hA5);
        repeat (20) step();
        check("R7 idle", ser_valid, 1'b0);
        // back-to-back bytes (R5)
        push_byte(8'h01); push_byte(8'h80); push_byte(8'hFF);
        repeat (40) step();
        // stalls with pending data
        ready_pct = 25;
        push_byte(8'h3C); push_byte(8'hC3);
        repeat (100) step();
        // random phases
        ready_pct = 60; push_pct = 20;
        repeat (3000) step();
        ready_pct = 30; push_pct = 50;
        repeat (2000) step();
        // drain
        ready_pct = 100; push_pct = 0;
        repeat (200) step();
        // R9: every queued bit went out, nothing extra
        check("R9 drained", (exp_bits.size() == 0 && bitpos == 0), 1'b1);
        check("R7 final idle", ser_valid, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule